// File: doc/BRIEF.md
# Dual-Counter Alarm Timer

This block keeps two free-running 52-bit time bases and raises alarms from three comparators. An external tick input, pulsed at the fixed 16 MHz rate that the clock logic supplies, advances each counter by one. A comparator watches one of the two counters and has two modes. In target mode it fires once when the counter reaches a 52-bit absolute value. In period mode it fires repeatedly, and each firing moves its target forward by a 26-bit interval.

Each counter can pause while the processor is stalled or halted in debug. Which of these two conditions pauses a counter is chosen per counter. Software can also place a new value into a counter. The new value takes effect on the next tick. Each comparator owns a sticky status bit that is cleared by writing one to it, and a per-comparator enable gates that status bit onto its interrupt line.

Software reaches the block through a simple word-wide register port. Writes take effect at the clock edge and reads are combinational from the address. Values are zero-extended into the 64-bit data word.

Top module: `tick_alarm_timer`

## Requirements
- R1: After reset both counters read 0, the status register (address 3) reads 0 and every irq output is low.
- R2: The control register at address 0 holds three bits per counter c, at bits 4c (run), 4c+1 (pause on cpu_stall) and 4c+2 (pause on dbg_halt). A running counter rises by exactly one on each cycle where tick is high and holds its value in every other cycle. Past the all-ones value it wraps to 0. A counter with its run bit clear does not move.
- R3: A counter whose pause-on-cpu bit is set holds while cpu_stall is high, and a counter whose pause-on-debug bit is set holds while dbg_halt is high. A counter whose corresponding pause bit is clear keeps counting while that input is high.
- R4: Counter c reads at address 8+c, and its load value is written at address 4+c. Writing bit c at address 1 requests a load. The counter keeps its old value until the next tick. On that tick it takes the load value, whatever its run and pause bits are, and it then counts on from there.
- R5: Comparator k is configured at address 12+k, with bit0 enabling it, bit1 selecting period mode and bit2 choosing counter 0 or 1. Its target is written and read at address 16+k. In target mode its status bit k sets one cycle after the chosen counter is at or beyond the target, so a target already passed fires at once. It fires only once until its target or configuration is written again.
- R6: In period mode the interval is written at address 20+k, and only its low 26 bits are kept. When the mode is enabled, the first target becomes the chosen counter plus the interval. Every firing adds the interval to the target, which reads back at address 16+k.
- R7: The select bit decides which counter a comparator is compared against. The value of the other counter has no effect on it.
- R8: A status bit stays set until software writes a one to its position at address 3. Writing zero there leaves it set.
- R9: Output irq[k] is high exactly when status bit k is set and enable bit k at address 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse at the fixed counting rate |
| cpu_stall | input | 1 | Processor stalled |
| dbg_halt | input | 1 | Processor halted in debug |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |
| irq | output | 3 | One interrupt per comparator |

## Verification
Counters are driven with tick bursts that interleave idle cycles, pause inputs and pending loads. This shows that counting happens on ticks alone, that each pause input matches only its own control bit, and that a load waits for a tick. A load near the all-ones value checks the wrap. Comparators are tried with a target still ahead, a target already passed and a repeating interval. These cases separate an at-or-past comparison from an equality test, a one-shot alarm from a re-arming one, and a correct period step from an off-by-one. A last case points a comparator at the lagging counter while the other counter is already past the target, which exposes a wrong counter selection.

// File: rtl/stimer_pkg.sv
package stimer_pkg;
   // register word addresses
   localparam int unsigned ADDR_W      = 5;
   localparam int unsigned MAX_UNITS   = 4;
   localparam int unsigned CTRL_STRIDE = 4;
   localparam int unsigned A_CTRL      = 0;
   localparam int unsigned A_LOADGO    = 1;
   localparam int unsigned A_INT_ENA   = 2;
   localparam int unsigned A_INT_STAT  = 3;
   localparam int unsigned A_LOAD_BASE = 4;
   localparam int unsigned A_CNT_BASE  = 8;
   localparam int unsigned A_CFG_BASE  = 12;
   localparam int unsigned A_TGT_BASE  = 16;
   localparam int unsigned A_PER_BASE  = 20;

   // bit positions inside a per-counter control nibble
   localparam int unsigned CB_RUN  = 0;
   localparam int unsigned CB_SCPU = 1;
   localparam int unsigned CB_SDBG = 2;

   // bit positions inside a comparator configuration word
   localparam int unsigned FB_EN  = 0;
   localparam int unsigned FB_PER = 1;
   localparam int unsigned FB_SEL = 2;

   typedef struct packed {
      logic run;
      logic pause_cpu;
      logic pause_dbg;
   } cnt_ctrl_t;
endpackage

// File: rtl/stimer_counter.sv
module stimer_counter #(
   parameter int unsigned CNT_W = 52
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             freeze,
   input  logic             load_req,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] value
);
   logic pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
         pend  <= 1'b0;
      end else if (tick) begin
         pend <= 1'b0;
         if (pend || load_req) begin
            value <= load_val;
         end else if (run && !freeze) begin
            value <= value + 1'b1;
         end
      end else if (load_req) begin
         pend <= 1'b1;
      end
   end
endmodule

// File: rtl/stimer_comparator.sv
module stimer_comparator #(
   parameter int unsigned CNT_W    = 52,
   parameter int unsigned PERIOD_W = 26
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                per_mode,
   input  logic                cfg_wr,
   input  logic                cfg_en_new,
   input  logic                cfg_per_new,
   input  logic                tgt_wr,
   input  logic [CNT_W-1:0]    tgt_wdata,
   input  logic [PERIOD_W-1:0] period,
   input  logic [CNT_W-1:0]    cnt_val,
   output logic                hit,
   output logic [CNT_W-1:0]    target
);
   logic             armed;
   logic [CNT_W-1:0] step;

   assign step = CNT_W'(period);
   assign hit  = en && armed && (cnt_val >= target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         target <= '0;
         armed  <= 1'b0;
      end else if (tgt_wr) begin
         target <= tgt_wdata;
         armed  <= 1'b1;
      end else if (cfg_wr) begin
         armed <= cfg_en_new;
         if (cfg_en_new && cfg_per_new) begin
            target <= cnt_val + step;
         end
      end else if (hit) begin
         if (per_mode) begin
            target <= target + step;
         end else begin
            armed <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/stimer_irq.sv
module stimer_irq #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hit,
   input  logic         ena_wr,
   input  logic         stat_wr,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] ena,
   output logic [N-1:0] status,
   output logic [N-1:0] irq
);
   logic [N-1:0] clr;

   assign clr = stat_wr ? wdata : '0;
   assign irq = status & ena;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena    <= '0;
         status <= '0;
      end else begin
         if (ena_wr) begin
            ena <= wdata;
         end
         status <= (status & ~clr) | hit;
      end
   end
endmodule

// File: rtl/tick_alarm_timer.sv
module tick_alarm_timer
   import stimer_pkg::*;
#(
   parameter int unsigned NUM_CNT  = 2,
   parameter int unsigned NUM_CMP  = 3,
   parameter int unsigned CNT_W    = 52,
   parameter int unsigned PERIOD_W = 26,
   parameter int unsigned DATA_W   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cpu_stall,
   input  logic              dbg_halt,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NUM_CMP-1:0] irq
);
   localparam int unsigned SEL_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

   // elaboration-time parameter checks
   if (NUM_CNT < 1 || NUM_CNT > MAX_UNITS) begin : g_bad_cnt
      $error("NUM_CNT out of range");
   end
   if (NUM_CMP < 1 || NUM_CMP > MAX_UNITS) begin : g_bad_cmp
      $error("NUM_CMP out of range");
   end
   if (PERIOD_W > CNT_W) begin : g_bad_per
      $error("PERIOD_W exceeds CNT_W");
   end
   if (CNT_W > DATA_W || CTRL_STRIDE * NUM_CNT > DATA_W) begin : g_bad_data
      $error("DATA_W too narrow");
   end

   cnt_ctrl_t [NUM_CNT-1:0]             cctl;
   logic [NUM_CNT-1:0][CNT_W-1:0]       load_val;
   logic [NUM_CNT-1:0][CNT_W-1:0]       cnt_val;
   logic [NUM_CNT-1:0]                  load_go;
   logic [NUM_CNT-1:0]                  load_wr;
   logic [NUM_CNT-1:0]                  freeze;

   logic [NUM_CMP-1:0]                  cmp_en;
   logic [NUM_CMP-1:0]                  cmp_per;
   logic [NUM_CMP-1:0][SEL_W-1:0]       cmp_sel;
   logic [NUM_CMP-1:0][SEL_W-1:0]       sel_eff;
   logic [NUM_CMP-1:0][PERIOD_W-1:0]    cmp_period;
   logic [NUM_CMP-1:0][CNT_W-1:0]       cmp_tgt;
   logic [NUM_CMP-1:0][CNT_W-1:0]       cmp_cnt;
   logic [NUM_CMP-1:0]                  cmp_hit;
   logic [NUM_CMP-1:0]                  cfg_wr;
   logic [NUM_CMP-1:0]                  tgt_wr;
   logic [NUM_CMP-1:0]                  per_wr;
   logic [NUM_CMP-1:0]                  cmp_wr;

   logic                                ctrl_wr;
   logic                                ena_wr;
   logic                                stat_wr;
   logic [NUM_CMP-1:0]                  int_ena;
   logic [NUM_CMP-1:0]                  int_stat;

   if (DATA_W > CNT_W) begin : g_sink
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CNT_W];
   end

   // ---------------- write decode ----------------
   assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
   assign ena_wr  = reg_wr && (reg_addr == ADDR_W'(A_INT_ENA));
   assign stat_wr = reg_wr && (reg_addr == ADDR_W'(A_INT_STAT));

   always_comb begin
      for (int c = 0; c < NUM_CNT; c++) begin
         load_wr[c] = reg_wr && (reg_addr == ADDR_W'(A_LOAD_BASE + c));
         load_go[c] = reg_wr && (reg_addr == ADDR_W'(A_LOADGO)) && reg_wdata[c];
         freeze[c]  = (cctl[c].pause_cpu && cpu_stall) ||
                      (cctl[c].pause_dbg && dbg_halt);
      end
      for (int k = 0; k < NUM_CMP; k++) begin
         cfg_wr[k] = reg_wr && (reg_addr == ADDR_W'(A_CFG_BASE + k));
         tgt_wr[k] = reg_wr && (reg_addr == ADDR_W'(A_TGT_BASE + k));
         per_wr[k] = reg_wr && (reg_addr == ADDR_W'(A_PER_BASE + k));
         cmp_wr[k] = cfg_wr[k] || tgt_wr[k];
      end
   end

   // ---------------- configuration storage ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cctl     <= '0;
         load_val <= '0;
      end else begin
         for (int c = 0; c < NUM_CNT; c++) begin
            if (ctrl_wr) begin
               cctl[c].run       <= reg_wdata[CTRL_STRIDE*c + CB_RUN];
               cctl[c].pause_cpu <= reg_wdata[CTRL_STRIDE*c + CB_SCPU];
               cctl[c].pause_dbg <= reg_wdata[CTRL_STRIDE*c + CB_SDBG];
            end
            if (load_wr[c]) begin
               load_val[c] <= reg_wdata[CNT_W-1:0];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_en     <= '0;
         cmp_per    <= '0;
         cmp_sel    <= '0;
         cmp_period <= '0;
      end else begin
         for (int k = 0; k < NUM_CMP; k++) begin
            if (cfg_wr[k]) begin
               cmp_en[k]  <= reg_wdata[FB_EN];
               cmp_per[k] <= reg_wdata[FB_PER];
               cmp_sel[k] <= reg_wdata[FB_SEL +: SEL_W];
            end
            if (per_wr[k]) begin
               cmp_period[k] <= reg_wdata[PERIOD_W-1:0];
            end
         end
      end
   end

   // ---------------- counters ----------------
   for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
      stimer_counter #(
         .CNT_W (CNT_W)
      ) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick),
         .run      (cctl[c].run),
         .freeze   (freeze[c]),
         .load_req (load_go[c]),
         .load_val (load_val[c]),
         .value    (cnt_val[c])
      );
   end

   // ---------------- counter routing to comparators ----------------
   always_comb begin
      for (int k = 0; k < NUM_CMP; k++) begin
         sel_eff[k] = cfg_wr[k] ? reg_wdata[FB_SEL +: SEL_W] : cmp_sel[k];
         cmp_cnt[k] = cnt_val[0];
         for (int c = 0; c < NUM_CNT; c++) begin
            if (sel_eff[k] == SEL_W'(c)) begin
               cmp_cnt[k] = cnt_val[c];
            end
         end
      end
   end

   // ---------------- comparators ----------------
   for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
      stimer_comparator #(
         .CNT_W    (CNT_W),
         .PERIOD_W (PERIOD_W)
      ) u_cmp (
         .clk         (clk),
         .rst_n       (rst_n),
         .en          (cmp_en[k]),
         .per_mode    (cmp_per[k]),
         .cfg_wr      (cfg_wr[k]),
         .cfg_en_new  (reg_wdata[FB_EN]),
         .cfg_per_new (reg_wdata[FB_PER]),
         .tgt_wr      (tgt_wr[k]),
         .tgt_wdata   (reg_wdata[CNT_W-1:0]),
         .period      (cmp_period[k]),
         .cnt_val     (cmp_cnt[k]),
         .hit         (cmp_hit[k]),
         .target      (cmp_tgt[k])
      );
   end

   // ---------------- interrupt status ----------------
   stimer_irq #(
      .N (NUM_CMP)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (cmp_hit),
      .ena_wr  (ena_wr),
      .stat_wr (stat_wr),
      .wdata   (reg_wdata[NUM_CMP-1:0]),
      .ena     (int_ena),
      .status  (int_stat),
      .irq     (irq)
   );

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(A_CTRL)) begin
         for (int c = 0; c < NUM_CNT; c++) begin
            reg_rdata[CTRL_STRIDE*c + CB_RUN]  = cctl[c].run;
            reg_rdata[CTRL_STRIDE*c + CB_SCPU] = cctl[c].pause_cpu;
            reg_rdata[CTRL_STRIDE*c + CB_SDBG] = cctl[c].pause_dbg;
         end
      end
      if (reg_addr == ADDR_W'(A_INT_ENA)) begin
         reg_rdata = DATA_W'(int_ena);
      end
      if (reg_addr == ADDR_W'(A_INT_STAT)) begin
         reg_rdata = DATA_W'(int_stat);
      end
      for (int c = 0; c < NUM_CNT; c++) begin
         if (reg_addr == ADDR_W'(A_LOAD_BASE + c)) begin
            reg_rdata = DATA_W'(load_val[c]);
         end
         if (reg_addr == ADDR_W'(A_CNT_BASE + c)) begin
            reg_rdata = DATA_W'(cnt_val[c]);
         end
      end
      for (int k = 0; k < NUM_CMP; k++) begin
         if (reg_addr == ADDR_W'(A_CFG_BASE + k)) begin
            reg_rdata[FB_EN]            = cmp_en[k];
            reg_rdata[FB_PER]           = cmp_per[k];
            reg_rdata[FB_SEL +: SEL_W]  = cmp_sel[k];
         end
         if (reg_addr == ADDR_W'(A_TGT_BASE + k)) begin
            reg_rdata = DATA_W'(cmp_tgt[k]);
         end
         if (reg_addr == ADDR_W'(A_PER_BASE + k)) begin
            reg_rdata = DATA_W'(cmp_period[k]);
         end
      end
   end
endmodule

// File: rtl/tick_alarm_timer_chk.sv
module tick_alarm_timer_chk #(
   parameter int unsigned NUM_CNT  = 2,
   parameter int unsigned NUM_CMP  = 3,
   parameter int unsigned CNT_W    = 52,
   parameter int unsigned PERIOD_W = 26,
   parameter int unsigned ADDR_W   = 5
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              tick,
   input logic                              reg_wr,
   input logic [ADDR_W-1:0]                 reg_addr,
   input logic [NUM_CMP-1:0]                clr_bits,
   input logic [NUM_CNT-1:0][CNT_W-1:0]     cnt_val,
   input logic [NUM_CMP-1:0]                cmp_hit,
   input logic [NUM_CMP-1:0]                cmp_per,
   input logic [NUM_CMP-1:0]                cmp_wr,
   input logic [NUM_CMP-1:0][CNT_W-1:0]     cmp_tgt,
   input logic [NUM_CMP-1:0][PERIOD_W-1:0]  cmp_period,
   input logic [NUM_CMP-1:0]                int_stat
);
   logic clr_access;
   assign clr_access = reg_wr && (reg_addr == ADDR_W'(3));

   for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt_chk
      AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !tick |=> $stable(cnt_val[c]));  // R2
   end

   for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp_chk
      AST_HIT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
         cmp_hit[k] |=> int_stat[k]);  // R5
      AST_TARGET_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
         (cmp_hit[k] && !cmp_per[k] && !cmp_wr[k]) |=> !cmp_hit[k]);  // R5
      AST_PERIOD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
         (cmp_hit[k] && cmp_per[k] && !cmp_wr[k]) |=>
            (cmp_tgt[k] == $past(cmp_tgt[k]) + CNT_W'($past(cmp_period[k]))));  // R6
      AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (int_stat[k] && !(clr_access && clr_bits[k])) |=> int_stat[k]);  // R8
   end
endmodule

bind tick_alarm_timer tick_alarm_timer_chk #(
   .NUM_CNT  (NUM_CNT),
   .NUM_CMP  (NUM_CMP),
   .CNT_W    (CNT_W),
   .PERIOD_W (PERIOD_W),
   .ADDR_W   (stimer_pkg::ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .clr_bits   (reg_wdata[NUM_CMP-1:0]),
   .cnt_val    (cnt_val),
   .cmp_hit    (cmp_hit),
   .cmp_per    (cmp_per),
   .cmp_wr     (cmp_wr),
   .cmp_tgt    (cmp_tgt),
   .cmp_period (cmp_period),
   .int_stat   (int_stat)
);

// File: tb/test_tick_alarm_timer.sv
`timescale 1ns/1ps
module test_tick_alarm_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        cpu_stall = 1'b0;
   logic        dbg_halt = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic [2:0]  irq;

   int n_tests = 0;
   int n_fail  = 0;
   logic [63:0] v;
   logic [63:0] c1;

   always #4 clk = ~clk;

   tick_alarm_timer i_tick_alarm_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cpu_stall (cpu_stall),
      .dbg_halt  (dbg_halt),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [63:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      rd(5'd8, v);  check("R1 cnt0 reset", v, 64'd0);
      rd(5'd9, v);  check("R1 cnt1 reset", v, 64'd0);
      rd(5'd3, v);  check("R1 status reset", v, 64'd0);
      check("R1 irq reset", {61'd0, irq}, 64'd0);
   endtask

   task automatic t_count();
      wr(5'd0, 64'h11);
      ticks(3);
      rd(5'd8, v);  check("R2 cnt0 after 3 ticks", v, 64'd3);
      rd(5'd9, v);  check("R2 cnt1 after 3 ticks", v, 64'd3);
      idle(6);
      rd(5'd8, v);  check("R2 cnt0 holds without tick", v, 64'd3);
      wr(5'd0, 64'h01);
      ticks(2);
      rd(5'd8, v);  check("R2 running cnt0", v, 64'd5);
      rd(5'd9, v);  check("R2 stopped cnt1", v, 64'd3);
   endtask

   task automatic t_stall();
      wr(5'd0, 64'h53);
      cpu_stall = 1'b1;
      ticks(2);
      rd(5'd8, v);  check("R3 cnt0 paused by cpu_stall", v, 64'd5);
      rd(5'd9, v);  check("R3 cnt1 ignores cpu_stall", v, 64'd5);
      cpu_stall = 1'b0; dbg_halt = 1'b1;
      ticks(2);
      rd(5'd8, v);  check("R3 cnt0 ignores dbg_halt", v, 64'd7);
      rd(5'd9, v);  check("R3 cnt1 paused by dbg_halt", v, 64'd5);
      dbg_halt = 1'b0;
   endtask

   task automatic t_load();
      wr(5'd0, 64'h01);
      wr(5'd4, 64'h000F_FFFF_FFFF_FF00);
      wr(5'd1, 64'h1);
      idle(3);
      rd(5'd8, v);  check("R4 load waits for tick", v, 64'd7);
      ticks(1);
      rd(5'd8, v);  check("R4 load applied on tick", v, 64'h000F_FFFF_FFFF_FF00);
      ticks(1);
      rd(5'd8, v);  check("R4 counts on after load", v, 64'h000F_FFFF_FFFF_FF01);
      rd(5'd9, v);  check("R4 other counter untouched", v, 64'd5);
      wr(5'd4, 64'h000F_FFFF_FFFF_FFFF);
      wr(5'd1, 64'h1);
      ticks(2);
      rd(5'd8, v);  check("R2 wrap to zero", v, 64'd0);
      wr(5'd4, 64'd100);
      wr(5'd1, 64'h1);
      ticks(1);
      rd(5'd8, v);  check("R4 reload 100", v, 64'd100);
   endtask

   task automatic t_target();
      wr(5'd0, 64'h11);
      wr(5'd2, 64'h7);
      wr(5'd16, 64'd104);
      wr(5'd12, 64'h1);
      ticks(3);
      rd(5'd3, v);  check("R5 no fire before target", v & 64'h1, 64'd0);
      ticks(1);
      rd(5'd3, v);  check("R5 fire at target", v & 64'h1, 64'd1);
      check("R9 irq0 with enable", {63'd0, irq[0]}, 64'd1);
      wr(5'd3, 64'h0);
      rd(5'd3, v);  check("R8 write zero keeps status", v & 64'h1, 64'd1);
      wr(5'd2, 64'h6);
      #1 check("R9 irq0 masked", {63'd0, irq[0]}, 64'd0);
      wr(5'd2, 64'h7);
      wr(5'd3, 64'h1);
      rd(5'd3, v);  check("R8 write one clears", v & 64'h1, 64'd0);
      ticks(2);
      rd(5'd3, v);  check("R5 one-shot does not refire", v & 64'h1, 64'd0);
      check("R9 irq0 low after clear", {63'd0, irq[0]}, 64'd0);
   endtask

   task automatic t_past();
      wr(5'd17, 64'd3);
      wr(5'd13, 64'h1);
      rd(5'd3, v);  check("R5 past target fires at once", v & 64'h2, 64'h2);
      wr(5'd3, 64'h2);
      rd(5'd3, v);  check("R8 clear comparator1", v & 64'h2, 64'd0);
   endtask

   task automatic t_period();
      rd(5'd8, c1);
      wr(5'd20, 64'h0000_0000_FC00_0005);
      rd(5'd20, v);  check("R6 period keeps low 26 bits", v, 64'h0000_0000_0000_0005);
      wr(5'd12, 64'h3);
      rd(5'd16, v);  check("R6 first target", v, c1 + 64'd5);
      ticks(4);
      rd(5'd3, v);  check("R6 no fire before interval", v & 64'h1, 64'd0);
      ticks(1);
      rd(5'd3, v);  check("R6 first period fire", v & 64'h1, 64'd1);
      rd(5'd16, v); check("R6 target advanced", v, c1 + 64'd10);
      wr(5'd3, 64'h1);
      ticks(4);
      rd(5'd3, v);  check("R6 quiet inside interval", v & 64'h1, 64'd0);
      ticks(1);
      rd(5'd3, v);  check("R6 second period fire", v & 64'h1, 64'd1);
      rd(5'd16, v); check("R6 target advanced twice", v, c1 + 64'd15);
      wr(5'd12, 64'h0);
      wr(5'd3, 64'h1);
   endtask

   task automatic t_select();
      rd(5'd9, c1);
      wr(5'd18, c1 + 64'd3);
      wr(5'd14, 64'h5);
      rd(5'd3, v);  check("R7 counter0 ahead ignored", v & 64'h4, 64'd0);
      ticks(2);
      rd(5'd3, v);  check("R7 no fire before counter1 target", v & 64'h4, 64'd0);
      ticks(1);
      rd(5'd3, v);  check("R7 fire from counter1", v & 64'h4, 64'h4);
      check("R9 irq2 raised", {63'd0, irq[2]}, 64'd1);
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      t_reset();
      t_count();
      t_stall();
      t_load();
      t_target();
      t_past();
      t_period();
      t_select();
      idle(2);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule